// File: doc/BRIEF.md
# AUX Channel Ownership Arbiter

This block decides who may drive a shared auxiliary signalling channel: a host software port or an embedded microcontroller. It holds a two-bit ownership status. The microcontroller takes the channel by holding a request level while nobody owns it. The host takes it through a one-cycle acquire pulse, which always ends in a single `acq_done` pulse with a grant or deny result. The host gives the channel back with a one-cycle release pulse.

The first host acquisition after reset, or after a failed handshake, finds the channel disabled. The block then raises the channel enable and the channel reset together. It polls the channel's reset-done indication at fixed intervals until that indication goes high. It then drops reset and polls until the indication goes low. Only after both phases does it claim ownership. Each phase has a bounded number of polls. A phase that runs out of polls ends the attempt with a deny and turns the channel off again. Once the channel is enabled it stays enabled, so later acquisitions skip the handshake.

Top module: `auxch_owner_arb`

## Requirements
- R1: Ownership status encoding is 0 = free, 1 = host owns, 2 = microcontroller owns, and 3 never occurs. After reset the status is 0 and `chan_en`, `chan_rst` and `acq_done` are all 0.
- R2: While the status is 0, a high `mcu_req` moves it to 2 on the next clock edge. While the status is 2, a low `mcu_req` returns it to 0. A high `mcu_req` does not take the channel while the status is 1.
- R3: An acquire pulse seen while the status is 2 produces `acq_done` with `acq_grant` = 0 on the same clock edge that samples the pulse. Status and `chan_en` are unchanged.
- R4: An acquire on a disabled channel raises `chan_en` and `chan_rst` together, and `chan_rst` is never high without `chan_en`. Reset is dropped at the first poll that sees `rst_done` high. Ownership is claimed one cycle after the first later poll that sees `rst_done` low. With a prompt channel the result arrives 2*POLL_GAP_CYC+1 edges after the sampling edge.
- R5: Polls occur every POLL_GAP_CYC cycles, at most POLL_POLLS per phase. When a phase exhausts its polls, the attempt ends with a deny on the last poll, and `chan_en` and `chan_rst` are both 0. A stuck-low `rst_done` gives the result POLL_POLLS*POLL_GAP_CYC edges after the sampling edge.
- R6: An acquire on an enabled channel skips the handshake: no reset pulse, and the result one edge after the sampling edge.
- R7: A grant is reported together with status 1. A claim is granted when the status is 1, or when it is 0 and `mcu_req` is low. Otherwise it is denied.
- R8: A release pulse while the status is 1 returns the status to 0 and leaves `chan_en` at 1. A release pulse while the status is 2 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acq_req | input | 1 | Host acquire pulse |
| rel_req | input | 1 | Host release (done using) pulse |
| mcu_req | input | 1 | Microcontroller ownership request level |
| rst_done | input | 1 | Channel reset-done indication |
| own_status | output | 2 | Ownership status (0 free, 1 host, 2 microcontroller) |
| acq_done | output | 1 | One-cycle pulse ending an acquire attempt |
| acq_grant | output | 1 | Acquire result, valid with `acq_done` |
| chan_en | output | 1 | Channel enable |
| chan_rst | output | 1 | Channel reset |

## Verification
The bench builds the arbiter with POLL_GAP_CYC = 8 and the default POLL_POLLS = 11, with the two-phase handshake present. The short poll gap makes both timeout paths cost under a hundred cycles each: `rst_done` stuck low, and `rst_done` stuck high after the first phase. It also lets the exact handshake latency, 17 edges, be compared against a formula. A channel model answers the reset with a delay shorter than one poll gap, or stays stuck. This reaches the normal path, both expiry paths, and recovery after a failure. A seeded random mix of acquire, release and microcontroller request changes is then checked against a bench model of the status.

// File: rtl/auxch_arb_pkg.sv
package auxch_arb_pkg;

   typedef enum logic [1:0] {
      OWN_FREE = 2'd0,
      OWN_HOST = 2'd1,
      OWN_MCU  = 2'd2
   } own_t;

   typedef enum logic [1:0] {
      S_IDLE    = 2'd0,
      S_WAIT_HI = 2'd1,
      S_WAIT_LO = 2'd2,
      S_CLAIM   = 2'd3
   } arb_st_t;

endpackage

// File: rtl/auxch_poll_timer.sv
module auxch_poll_timer #(
   parameter int GAP_CYC = 100,
   parameter int POLLS   = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick,
   output logic last
);
   localparam int GW = $clog2(GAP_CYC + 1);
   localparam int PW = $clog2(POLLS + 1);
   localparam logic [GW-1:0] GAP_END  = GW'(GAP_CYC - 1);
   localparam logic [PW-1:0] POLL_END = PW'(POLLS - 1);

   logic [GW-1:0] gap_q;
   logic [PW-1:0] poll_q;

   assign tick = (gap_q == GAP_END);
   assign last = tick && (poll_q == POLL_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         poll_q <= '0;
      end else if (clr) begin
         gap_q  <= '0;
         poll_q <= '0;
      end else if (tick) begin
         gap_q  <= '0;
         poll_q <= poll_q + 1'b1;
      end else begin
         gap_q  <= gap_q + 1'b1;
      end
   end
endmodule

// File: rtl/auxch_own_reg.sv
module auxch_own_reg
   import auxch_arb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic mcu_req,
   input  logic host_rel,
   input  logic host_take,
   output own_t own_q
);
   own_t own_d;

   always_comb begin
      own_d = own_q;
      if (own_q == OWN_FREE && mcu_req)
         own_d = OWN_MCU;
      else if (own_q == OWN_MCU && !mcu_req)
         own_d = OWN_FREE;
      else if (host_take)
         own_d = OWN_HOST;
      else if (own_q == OWN_HOST && host_rel)
         own_d = OWN_FREE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) own_q <= OWN_FREE;
      else        own_q <= own_d;
   end
endmodule

// File: rtl/auxch_owner_arb.sv
module auxch_owner_arb
   import auxch_arb_pkg::*;
#(
   parameter int POLL_GAP_CYC = 100,
   parameter int POLL_POLLS   = 11,
   parameter bit HAS_RESET    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       acq_req,
   input  logic       rel_req,
   input  logic       mcu_req,
   input  logic       rst_done,
   output logic [1:0] own_status,
   output logic       acq_done,
   output logic       acq_grant,
   output logic       chan_en,
   output logic       chan_rst
);
   initial begin
      assert (POLL_GAP_CYC >= 1) else $error("POLL_GAP_CYC must be at least 1");
      assert (POLL_POLLS >= 1)   else $error("POLL_POLLS must be at least 1");
   end

   arb_st_t state_q;
   own_t    own_q;
   arb_st_t first_st;
   logic    rst_on_entry;
   logic    tick, last, in_wait, phase_ok, tmr_clr, claim_ok, host_take;

   generate
      if (HAS_RESET) begin : g_hs
         assign first_st     = S_WAIT_HI;
         assign rst_on_entry = 1'b1;
      end else begin : g_nohs
         assign first_st     = S_CLAIM;
         assign rst_on_entry = 1'b0;
      end
   endgenerate

   assign in_wait   = (state_q == S_WAIT_HI) || (state_q == S_WAIT_LO);
   assign phase_ok  = (state_q == S_WAIT_HI) ? rst_done : !rst_done;
   assign tmr_clr   = !in_wait || (tick && phase_ok);
   assign claim_ok  = (own_q == OWN_HOST) || (own_q == OWN_FREE && !mcu_req);
   assign host_take = (state_q == S_CLAIM) && claim_ok;

   auxch_poll_timer #(
      .GAP_CYC (POLL_GAP_CYC),
      .POLLS   (POLL_POLLS)
   ) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .tick  (tick),
      .last  (last)
   );

   auxch_own_reg u_own (
      .clk       (clk),
      .rst_n     (rst_n),
      .mcu_req   (mcu_req),
      .host_rel  (rel_req),
      .host_take (host_take),
      .own_q     (own_q)
   );

   assign own_status = own_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         chan_en   <= 1'b0;
         chan_rst  <= 1'b0;
         acq_done  <= 1'b0;
         acq_grant <= 1'b0;
      end else begin
         acq_done  <= 1'b0;
         acq_grant <= 1'b0;
         case (state_q)
            S_IDLE: begin
               if (acq_req) begin
                  if (own_q == OWN_MCU) begin
                     acq_done <= 1'b1;
                  end else if (!chan_en) begin
                     chan_en  <= 1'b1;
                     chan_rst <= rst_on_entry;
                     state_q  <= first_st;
                  end else begin
                     state_q  <= S_CLAIM;
                  end
               end
            end
            S_WAIT_HI, S_WAIT_LO: begin
               if (tick) begin
                  if (phase_ok) begin
                     chan_rst <= 1'b0;
                     state_q  <= (state_q == S_WAIT_HI) ? S_WAIT_LO : S_CLAIM;
                  end else if (last) begin
                     chan_en  <= 1'b0;
                     chan_rst <= 1'b0;
                     acq_done <= 1'b1;
                     state_q  <= S_IDLE;
                  end
               end
            end
            default: begin
               acq_done  <= 1'b1;
               acq_grant <= claim_ok;
               state_q   <= S_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/auxch_owner_arb_chk.sv
module auxch_owner_arb_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rel_req,
   input logic       mcu_req,
   input logic [1:0] own_status,
   input logic       acq_done,
   input logic       acq_grant,
   input logic       chan_en,
   input logic       chan_rst
);
   AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      own_status != 2'd3); // R1
   AST_MCU_TAKES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (own_status == 2'd0 && mcu_req) |=> own_status == 2'd2); // R2
   AST_RST_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
      chan_rst |-> chan_en); // R4
   AST_GRANT_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_done && acq_grant) |-> own_status == 2'd1); // R7
   AST_HOST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (own_status == 2'd1 && !rel_req) |=> own_status == 2'd1); // R8
endmodule

bind auxch_owner_arb auxch_owner_arb_chk u_chk (.*);

// File: tb/tb_auxch_owner_arb.sv
module tb_auxch_owner_arb;
   localparam int CLK_NS = 10;
   localparam int GAP    = 8;
   localparam int POLLS  = 11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acq_req = 1'b0, rel_req = 1'b0, mcu_req = 1'b0, rst_done = 1'b0;
   logic [1:0] own_status;
   logic acq_done, acq_grant, chan_en, chan_rst;

   int total = 0, bad = 0;
   int resp_mode = 0, rcnt = 0;
   bit saw_rst = 0, rst_without_en = 0;

   always #(CLK_NS/2) clk = ~clk;

   auxch_owner_arb #(.POLL_GAP_CYC(GAP), .POLL_POLLS(POLLS)) dut (
      .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .rel_req(rel_req),
      .mcu_req(mcu_req), .rst_done(rst_done), .own_status(own_status),
      .acq_done(acq_done), .acq_grant(acq_grant), .chan_en(chan_en),
      .chan_rst(chan_rst));

   // channel model: answers reset after 3 cycles, or sticks
   always @(negedge clk) begin
      if (chan_rst) saw_rst = 1;
      if (chan_rst && !chan_en) rst_without_en = 1;
      case (resp_mode)
         0: begin
            if (chan_rst != rst_done) begin
               rcnt++;
               if (rcnt >= 3) begin rst_done = chan_rst; rcnt = 0; end
            end else rcnt = 0;
         end
         1: rst_done = 1'b0;
         default: if (chan_rst) rst_done = 1'b1;
      endcase
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; acq_req = 0; rel_req = 0; mcu_req = 0;
      resp_mode = 0; rst_done = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic acquire(output int lat, output bit g);
      @(negedge clk);
      acq_req = 1'b1;
      lat = 0; g = 0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         acq_req = 1'b0;
         lat++;
         if (acq_done) begin g = acq_grant; break; end
      end
      @(negedge clk);
   endtask

   task automatic release_pulse();
      @(negedge clk); rel_req = 1'b1;
      @(negedge clk); rel_req = 1'b0;
      @(negedge clk);
   endtask

   function automatic int mcu_step(input int st, input bit m);
      if (st == 0 && m) return 2;
      if (st == 2 && !m) return 0;
      return st;
   endfunction

   initial begin
      int lat; bit g; int st_m; bit en_m;
      void'($urandom(32'h5eed_0a1c));
      do_reset();
      // R1 reset state
      chk(own_status == 0, "R1 status after reset", own_status, 0);
      chk(chan_en == 0 && chan_rst == 0, "R1 enable/reset after reset", {chan_en, chan_rst}, 0);
      chk(acq_done == 0, "R1 done after reset", acq_done, 0);

      // R4 first acquisition with handshake
      saw_rst = 0;
      acquire(lat, g);
      chk(lat == 2*GAP+2, "R4 handshake latency", lat, 2*GAP+2);
      chk(g == 1, "R4 grant after handshake", g, 1);
      chk(saw_rst == 1 && rst_without_en == 0, "R4 reset only with enable", {saw_rst, rst_without_en}, 2);
      chk(own_status == 1, "R7 status host after grant", own_status, 1);
      chk(chan_en == 1 && chan_rst == 0, "R4 channel on, reset off", {chan_en, chan_rst}, 2);

      // R8 release
      release_pulse();
      chk(own_status == 0, "R8 release frees", own_status, 0);
      chk(chan_en == 1, "R8 channel stays enabled", chan_en, 1);

      // R6 fast path
      saw_rst = 0;
      acquire(lat, g);
      chk(lat == 2, "R6 fast latency", lat, 2);
      chk(g == 1 && saw_rst == 0, "R6 grant without reset", {g, saw_rst}, 2);

      // R2 mcu cannot preempt host, takes after release
      @(negedge clk); mcu_req = 1'b1;
      repeat (3) @(negedge clk);
      chk(own_status == 1, "R2 no preempt of host", own_status, 1);
      release_pulse();
      @(negedge clk);
      chk(own_status == 2, "R2 mcu takes free channel", own_status, 2);

      // R3 deny while mcu owns
      acquire(lat, g);
      chk(lat == 1 && g == 0, "R3 immediate deny", lat*2+g, 2);
      chk(own_status == 2 && chan_en == 1, "R3 state unchanged", {own_status, chan_en}, 5);
      release_pulse();
      chk(own_status == 2, "R8 release ignored under mcu", own_status, 2);
      @(negedge clk); mcu_req = 1'b0;
      @(negedge clk); @(negedge clk);
      chk(own_status == 0, "R2 mcu drop frees", own_status, 0);

      // R5 timeout, rst_done stuck low
      do_reset();
      resp_mode = 1;
      acquire(lat, g);
      chk(lat == POLLS*GAP+1, "R5 phase-one timeout latency", lat, POLLS*GAP+1);
      chk(g == 0 && chan_en == 0 && chan_rst == 0, "R5 deny and channel off", {g, chan_en, chan_rst}, 0);
      chk(own_status == 0, "R5 status free after timeout", own_status, 0);

      // R5 timeout, rst_done stuck high
      resp_mode = 2;
      acquire(lat, g);
      chk(lat >= POLLS*GAP+GAP && lat <= POLLS*GAP+GAP+2, "R5 phase-two timeout latency", lat, POLLS*GAP+GAP+1);
      chk(g == 0 && chan_en == 0 && chan_rst == 0, "R5 deny after phase two", {g, chan_en, chan_rst}, 0);

      // R4 recovery after failure
      @(negedge clk); resp_mode = 0; rst_done = 1'b0;
      repeat (2) @(negedge clk);
      acquire(lat, g);
      chk(lat == 2*GAP+2 && g == 1, "R4 recovery handshake", lat, 2*GAP+2);

      // random mix against model (R2 R3 R7 R8)
      st_m = 1; en_m = 1;
      for (int n = 0; n < 60; n++) begin
         int op;
         op = $urandom_range(0, 2);
         if (op == 0) begin
            @(negedge clk); mcu_req = $urandom_range(0, 1);
            repeat (2) @(negedge clk);
            st_m = mcu_step(st_m, mcu_req);
            chk(own_status == st_m, "R2 random mcu change", own_status, st_m);
         end else if (op == 1) begin
            acquire(lat, g);
            chk(g == (st_m != 2), "R7 random grant", g, st_m != 2);
            chk(lat == ((st_m == 2) ? 1 : 2), "R6 random latency", lat, (st_m == 2) ? 1 : 2);
            if (st_m != 2) st_m = 1;
            chk(own_status == st_m, "R3 random status after acquire", own_status, st_m);
         end else begin
            release_pulse();
            if (st_m == 1) st_m = 0;
            @(negedge clk);
            st_m = mcu_step(st_m, mcu_req);
            chk(own_status == st_m, "R8 random release", own_status, st_m);
         end
      end
      chk(chan_en == en_m, "R8 channel enabled through mix", chan_en, en_m);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_NS * 150000);
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule